// File: doc/BRIEF.md
# Dual-Processor Handshake Mailbox Latch

This block passes single bytes in both directions between a host processor bus and a small microcontroller. The microcontroller sees three 8-bit I/O ports. Each port has an output register and a direction register. Each port read merges the output register on bits set as outputs with the port's input value on bits set as inputs.

The microcontroller moves bytes in software by toggling port B output bits:
- A falling level on port B bit 1 pulls the host's byte into the port A input register.
- A rising level on port B bit 2 pushes the port A output register into the host-bound latch.

Port C and the host status byte each report which latches are occupied. The two sides use opposite senses for the host-bound flag. A host write raises the microcontroller interrupt. The interrupt stays raised until the microcontroller takes that byte.

Two two-state machines hold the pending flags:
- Host-to-microcontroller machine, states `H2M_EMPTY` and `H2M_FULL`.
  - A host write moves EMPTY→FULL.
  - A take edge without a host write in the same cycle moves FULL→EMPTY.
  - A host write while FULL stays FULL.
- Microcontroller-to-host machine, states `M2H_EMPTY` and `M2H_FULL`.
  - A send edge moves EMPTY→FULL.
  - A host read without a send edge in the same cycle moves FULL→EMPTY.
  - A send while FULL stays FULL.

Top module: `mbx_bridge`

## Requirements
- R1: Each port read returns, bit by bit, the output register where the direction bit is 1 and the port input value where it is 0. The port A input value is the take register. Every port B input bit reads 1.
- R2: A port B write in which bit 1 is an output (direction bit 1 = 1), the old output bit 1 is 1 and the new bit 1 is 0 copies the host-to-MCU latch into the port A input register. It clears the host-pending flag and drops `mcu_irq`.
- R3: A port B write in which bit 2 is an output, the old output bit 2 is 0 and the new bit 2 is 1 copies the port A output register, as it was before that clock, into the MCU-to-host latch. It sets the MCU-pending flag.
- R4: A host write stores `host_wdata` in the host-to-MCU latch, sets the host-pending flag and raises `mcu_irq` from the next cycle.
- R5: `host_rdata` always shows the MCU-to-host latch. A host read clears the MCU-pending flag.
- R6: The port C input value has bit 0 = host-pending, bit 1 = NOT MCU-pending, and bits 7..2 = 1.
- R7: `host_status` bit 0 is 1 when no host byte is pending. Bit 1 is 1 when an MCU byte is pending. Bits 7..2 are 0.
- R8: A port B write does not move a byte when the relevant direction bit is 0, or when the bit does not make the required transition.
- R9: When a host write and a take edge fall in the same cycle, the port A input register receives the old latch. The latch takes the new byte, and the flag and `mcu_irq` stay set.
- R10: When a send edge and a host read fall in the same cycle, the MCU-pending flag stays set and the latch takes the new byte.
- R11: `bus_req` equals port B bit 3 as read, that is the output bit when configured as output, else 1.
- R12: A synchronous active-high reset clears latches, flags, output and direction registers. It drops `mcu_irq`, so status reads 0x01 and port C reads 0xFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host data write strobe |
| host_rd | input | 1 | Host data read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | MCU-to-host latch |
| host_status | output | 8 | Host status byte |
| mcu_pa_we | input | 1 | Port A output register write |
| mcu_pb_we | input | 1 | Port B output register write |
| mcu_pc_we | input | 1 | Port C output register write |
| mcu_dda_we | input | 1 | Port A direction write |
| mcu_ddb_we | input | 1 | Port B direction write |
| mcu_ddc_we | input | 1 | Port C direction write |
| mcu_wdata | input | 8 | Microcontroller write byte |
| mcu_pa_rd | output | 8 | Port A read value |
| mcu_pb_rd | output | 8 | Port B read value |
| mcu_pc_rd | output | 8 | Port C read value |
| mcu_irq | output | 1 | Microcontroller interrupt request |
| bus_req | output | 1 | Bus request pin level (port B bit 3) |

## Verification
Directed sequences drive clean take and send edges. They also try the same port B writes with the direction bit cleared, or with the bit already at its final level. This separates true edge detection from level-sensitive or direction-blind detection. Same-cycle collisions of host write with take, and of host read with send, show which side wins in each machine. A long run of random mixed strobes, direction changes and occasional resets then checks every output against a reference model each cycle. That run catches polarity and priority slips in the port C and status encodings.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int DW        = 8;
    localparam int TAKE_BIT  = 1;
    localparam int SEND_BIT  = 2;
    localparam int BUSRQ_BIT = 3;
    localparam int PC_HPEND  = 0;
    localparam int PC_MRDY   = 1;
    localparam int ST_HRDY   = 0;
    localparam int ST_MPEND  = 1;

    typedef enum logic { H2M_EMPTY = 1'b0, H2M_FULL = 1'b1 } h2m_state_t;
    typedef enum logic { M2H_EMPTY = 1'b0, M2H_FULL = 1'b1 } m2h_state_t;

    function automatic logic [DW-1:0] port_mux(input logic [DW-1:0] outv,
                                               input logic [DW-1:0] dirv,
                                               input logic [DW-1:0] inv);
        return (outv & dirv) | (inv & ~dirv);
    endfunction
endpackage

// File: rtl/mbx_port.sv
module mbx_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         out_we,
    input  logic         dir_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] out_q,
    output logic [W-1:0] dir_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            dir_q <= '0;
        end else begin
            if (out_we) out_q <= wdata;
            if (dir_we) dir_q <= wdata;
        end
    end
endmodule

// File: rtl/mbx_edge.sv
module mbx_edge #(
    parameter int W     = 8,
    parameter int TAKE  = 1,
    parameter int SEND  = 2
) (
    input  logic         pb_we,
    input  logic [W-1:0] pb_old,
    input  logic [W-1:0] pb_new,
    input  logic [W-1:0] pb_dir,
    output logic         take,
    output logic         send
);
    always_comb begin
        take = pb_we && pb_dir[TAKE] && pb_old[TAKE] && !pb_new[TAKE];
        send = pb_we && pb_dir[SEND] && !pb_old[SEND] && pb_new[SEND];
    end
endmodule

// File: rtl/mbx_h2m_fsm.sv
module mbx_h2m_fsm
    import mbx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         take,
    output logic [W-1:0] data_q,
    output logic         pending,
    output logic         irq
);
    h2m_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= H2M_EMPTY;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (wr) data_q <= wdata;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            H2M_EMPTY: if (wr) state_d = H2M_FULL;
            H2M_FULL:  if (take && !wr) state_d = H2M_EMPTY;
            default:   state_d = H2M_EMPTY;
        endcase
    end

    always_comb begin
        pending = (state_q == H2M_FULL);
        irq     = pending;
    end
endmodule

// File: rtl/mbx_m2h_fsm.sv
module mbx_m2h_fsm
    import mbx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         send,
    input  logic [W-1:0] sdata,
    input  logic         rd,
    output logic [W-1:0] data_q,
    output logic         pending
);
    m2h_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= M2H_EMPTY;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (send) data_q <= sdata;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            M2H_EMPTY: if (send) state_d = M2H_FULL;
            M2H_FULL:  if (rd && !send) state_d = M2H_EMPTY;
            default:   state_d = M2H_EMPTY;
        endcase
    end

    always_comb pending = (state_q == M2H_FULL);
endmodule

// File: rtl/mbx_bridge.sv
module mbx_bridge
    import mbx_pkg::*;
#(
    parameter int DATA_W = mbx_pkg::DW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic [DATA_W-1:0] host_status,
    input  logic              mcu_pa_we,
    input  logic              mcu_pb_we,
    input  logic              mcu_pc_we,
    input  logic              mcu_dda_we,
    input  logic              mcu_ddb_we,
    input  logic              mcu_ddc_we,
    input  logic [DATA_W-1:0] mcu_wdata,
    output logic [DATA_W-1:0] mcu_pa_rd,
    output logic [DATA_W-1:0] mcu_pb_rd,
    output logic [DATA_W-1:0] mcu_pc_rd,
    output logic              mcu_irq,
    output logic              bus_req
);
    logic [DATA_W-1:0] pa_out, pa_dir, pb_out, pb_dir, pc_out, pc_dir;
    logic [DATA_W-1:0] pa_in_q, pc_in, h2m_data;
    logic              take_p, send_p, h2m_pend, m2h_pend;

    mbx_port #(.W(DATA_W)) u_pa (
        .clk(clk), .rst(rst), .out_we(mcu_pa_we), .dir_we(mcu_dda_we),
        .wdata(mcu_wdata), .out_q(pa_out), .dir_q(pa_dir));
    mbx_port #(.W(DATA_W)) u_pb (
        .clk(clk), .rst(rst), .out_we(mcu_pb_we), .dir_we(mcu_ddb_we),
        .wdata(mcu_wdata), .out_q(pb_out), .dir_q(pb_dir));
    mbx_port #(.W(DATA_W)) u_pc (
        .clk(clk), .rst(rst), .out_we(mcu_pc_we), .dir_we(mcu_ddc_we),
        .wdata(mcu_wdata), .out_q(pc_out), .dir_q(pc_dir));

    mbx_edge #(.W(DATA_W), .TAKE(TAKE_BIT), .SEND(SEND_BIT)) u_edge (
        .pb_we(mcu_pb_we), .pb_old(pb_out), .pb_new(mcu_wdata),
        .pb_dir(pb_dir), .take(take_p), .send(send_p));

    mbx_h2m_fsm #(.W(DATA_W)) u_h2m (
        .clk(clk), .rst(rst), .wr(host_wr), .wdata(host_wdata),
        .take(take_p), .data_q(h2m_data), .pending(h2m_pend), .irq(mcu_irq));

    mbx_m2h_fsm #(.W(DATA_W)) u_m2h (
        .clk(clk), .rst(rst), .send(send_p), .sdata(pa_out),
        .rd(host_rd), .data_q(host_rdata), .pending(m2h_pend));

    // Take register: port A input value
    always_ff @(posedge clk) begin
        if (rst)         pa_in_q <= '0;
        else if (take_p) pa_in_q <= h2m_data;
    end

    always_comb begin
        pc_in            = '1;
        pc_in[PC_HPEND]  = h2m_pend;
        pc_in[PC_MRDY]   = !m2h_pend;
        host_status           = '0;
        host_status[ST_HRDY]  = !h2m_pend;
        host_status[ST_MPEND] = m2h_pend;
    end

    always_comb begin
        mcu_pa_rd = port_mux(pa_out, pa_dir, pa_in_q);
        mcu_pb_rd = port_mux(pb_out, pb_dir, '1);
        mcu_pc_rd = port_mux(pc_out, pc_dir, pc_in);
        bus_req   = mcu_pb_rd[BUSRQ_BIT];
    end
endmodule

// File: rtl/mbx_bridge_chk.sv
module mbx_bridge_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         host_wr,
    input logic         host_rd,
    input logic [W-1:0] host_rdata,
    input logic [W-1:0] host_status,
    input logic         mcu_irq,
    input logic         take_p,
    input logic         send_p,
    input logic [W-1:0] pb_dir,
    input logic [W-1:0] h2m_data,
    input logic [W-1:0] pa_in_q,
    input logic [W-1:0] pa_out
);
    p_write_raises_irq_r4: assert property (@(posedge clk) disable iff (rst)
        host_wr |=> (mcu_irq && !host_status[0]));
    p_take_clears_r2: assert property (@(posedge clk) disable iff (rst)
        (take_p && !host_wr) |=> (!mcu_irq && host_status[0]));
    p_take_loads_r2: assert property (@(posedge clk) disable iff (rst)
        take_p |=> (pa_in_q == $past(h2m_data)));
    p_send_loads_r3: assert property (@(posedge clk) disable iff (rst)
        send_p |=> (host_status[1] && host_rdata == $past(pa_out)));
    p_read_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !send_p) |=> !host_status[1]);
    p_take_needs_dir_r8: assert property (@(posedge clk) disable iff (rst)
        take_p |-> pb_dir[1]);
    p_send_needs_dir_r8: assert property (@(posedge clk) disable iff (rst)
        send_p |-> pb_dir[2]);
    p_write_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (host_wr && take_p) |=> mcu_irq);
    p_status_upper_r7: assert property (@(posedge clk) disable iff (rst)
        host_status[W-1:2] == '0);
    p_reset_state_r12: assert property (@(posedge clk)
        rst |=> (!mcu_irq && host_status == 8'h01));
endmodule

bind mbx_bridge mbx_bridge_chk #(.W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_rdata(host_rdata), .host_status(host_status), .mcu_irq(mcu_irq),
    .take_p(take_p), .send_p(send_p), .pb_dir(pb_dir), .h2m_data(h2m_data),
    .pa_in_q(pa_in_q), .pa_out(pa_out));

// File: tb/mbx_bridge_bench.sv
module mbx_bridge_bench;
    logic clk = 1'b0;
    logic rst;
    logic host_wr, host_rd;
    logic [7:0] host_wdata, host_rdata, host_status;
    logic pa_we, pb_we, pc_we, dda_we, ddb_we, ddc_we;
    logic [7:0] wdata, pa_rd, pb_rd, pc_rd;
    logic irq, bus_req;

    int vectors = 0;
    int miscompares = 0;

    // reference model state
    logic [7:0] m_oa, m_ob, m_oc, m_da, m_db, m_dc, m_pain, m_h2m, m_m2h;
    logic m_hp, m_mp;

    always #5 clk = ~clk;

    mbx_bridge u_mbx_bridge (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_status(host_status),
        .mcu_pa_we(pa_we), .mcu_pb_we(pb_we), .mcu_pc_we(pc_we),
        .mcu_dda_we(dda_we), .mcu_ddb_we(ddb_we), .mcu_ddc_we(ddc_we),
        .mcu_wdata(wdata), .mcu_pa_rd(pa_rd), .mcu_pb_rd(pb_rd), .mcu_pc_rd(pc_rd),
        .mcu_irq(irq), .bus_req(bus_req));

    function automatic logic [7:0] mux(input logic [7:0] o, input logic [7:0] d,
                                       input logic [7:0] i);
        return (o & d) | (i & ~d);
    endfunction

    function automatic logic [7:0] exp_pc_in();
        return {6'h3F, !m_mp, m_hp};
    endfunction

    function automatic logic [7:0] exp_status();
        return {6'h00, m_mp, !m_hp};
    endfunction

    task automatic chk(input string ctx, input string req, input logic [7:0] act,
                       input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s act=%02h exp=%02h t=%0t", req, ctx, act, exp, $time);
        end
    endtask

    task automatic idle();
        rst = 0; host_wr = 0; host_rd = 0; pa_we = 0; pb_we = 0; pc_we = 0;
        dda_we = 0; ddb_we = 0; ddc_we = 0;
    endtask

    task automatic model_clock();
        logic tk, sd;
        logic [7:0] pa_old;
        if (rst) begin
            {m_oa, m_ob, m_oc, m_da, m_db, m_dc} = '0;
            {m_pain, m_h2m, m_m2h} = '0;
            m_hp = 0; m_mp = 0;
            return;
        end
        tk = pb_we && m_db[1] && m_ob[1] && !wdata[1];
        sd = pb_we && m_db[2] && !m_ob[2] && wdata[2];
        pa_old = m_oa;
        if (tk) m_pain = m_h2m;
        if (host_wr) begin m_h2m = host_wdata; m_hp = 1; end
        else if (tk) m_hp = 0;
        if (sd) begin m_m2h = pa_old; m_mp = 1; end
        else if (host_rd) m_mp = 0;
        if (pa_we) m_oa = wdata;
        if (pb_we) m_ob = wdata;
        if (pc_we) m_oc = wdata;
        if (dda_we) m_da = wdata;
        if (ddb_we) m_db = wdata;
        if (ddc_we) m_dc = wdata;
    endtask

    task automatic step(input string ctx);
        logic [7:0] pbx;
        @(posedge clk);
        model_clock();
        @(negedge clk);
        pbx = mux(m_ob, m_db, 8'hFF);
        chk(ctx, "R1", pa_rd, mux(m_oa, m_da, m_pain));
        chk(ctx, "R1", pb_rd, pbx);
        chk(ctx, "R6", pc_rd, mux(m_oc, m_dc, exp_pc_in()));
        chk(ctx, "R7", host_status, exp_status());
        chk(ctx, "R5", host_rdata, m_m2h);
        chk(ctx, "R4", {7'd0, irq}, {7'd0, m_hp});
        chk(ctx, "R11", {7'd0, bus_req}, {7'd0, pbx[3]});
        idle();
    endtask

    task automatic wr_reg(input string ctx, input int which, input logic [7:0] v);
        wdata = v;
        case (which)
            0: pa_we = 1; 1: pb_we = 1; 2: pc_we = 1;
            3: dda_we = 1; 4: ddb_we = 1; default: ddc_we = 1;
        endcase
        step(ctx);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        idle(); wdata = 0; host_wdata = 0;
        rst = 1;
        @(negedge clk);
        rst = 1; step("R12 reset");
        chk("R12", "R12", pc_rd, 8'hFE);
        chk("R12", "R12", host_status, 8'h01);

        // take edge
        wr_reg("setup", 4, 8'h0E);
        wr_reg("setup", 1, 8'h02);
        host_wr = 1; host_wdata = 8'hA5; step("R4 write");
        wr_reg("R2 take", 1, 8'h00);
        chk("R2", "R2", pa_rd, 8'hA5);
        // send edge
        wr_reg("setup", 3, 8'hFF);
        wr_reg("setup", 0, 8'h3C);
        wr_reg("R3 send", 1, 8'h04);
        chk("R3", "R3", host_rdata, 8'h3C);
        host_rd = 1; step("R5 read");
        // ignored edges
        host_wr = 1; host_wdata = 8'h11; step("R8 setup");
        wr_reg("R8", 4, 8'h04);
        wr_reg("R8", 1, 8'h06);
        wr_reg("R8 dir clear", 1, 8'h04);
        chk("R8", "R8", {7'd0, irq}, 8'h01);
        chk("R8", "R8", host_status, 8'h00);
        // same-cycle write and take
        wr_reg("R9", 3, 8'h00);
        wr_reg("R9", 4, 8'h0E);
        wr_reg("R9", 1, 8'h02);
        host_wr = 1; host_wdata = 8'h77; wdata = 8'h00; pb_we = 1; step("R9 collide");
        chk("R9", "R9", pa_rd, 8'h11);
        chk("R9", "R9", {7'd0, irq}, 8'h01);
        // same-cycle send and read
        wr_reg("R10", 0, 8'h5A);
        host_rd = 1; wdata = 8'h04; pb_we = 1; step("R10 collide");
        chk("R10", "R10", host_status[1] ? 8'h01 : 8'h00, 8'h01);
        // bus request pin
        wr_reg("R11", 1, 8'h08);
        wr_reg("R11", 1, 8'h00);
        wr_reg("R11", 4, 8'h00);

        for (int i = 0; i < 6000; i++) begin
            int unsigned r;
            r = $urandom;
            host_wr = (r[2:0] == 0); host_rd = (r[5:3] == 0);
            host_wdata = 8'($urandom);
            wdata = 8'($urandom);
            pb_we = (r[7:6] == 0);
            pa_we = (r[10:8] == 0);
            pc_we = (r[13:11] == 0);
            dda_we = (r[17:14] == 0);
            ddb_we = (r[21:18] == 0);
            ddc_we = (r[25:22] == 0);
            rst = (r[31:26] == 0) && (i % 7 == 0);
            step("random");
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule